// File: doc/BRIEF.md
# Serial EEPROM Configuration Preload Controller

This block fills a chip's configuration registers from an external Microwire serial EEPROM (byte-organized, 512 bytes) each time the registers are reset. It makes a slow serial clock from the system clock. It waits until every reset source has let go. It then sends one sequential read command. After that it keeps chip select asserted and keeps clocking, so the whole image streams out in a single transfer. Each received byte is handed to the register file through a simple write port, together with its byte index.

The first two bits that come back act as an enable signature and must be 1 then 0. Any other pair ends the load at once, and the registers keep their reset values. This includes the all-ones pattern read when no EEPROM is fitted and the data line is pulled high. While a load is pending or running, the block tells the configuration-access logic to answer with a retry. That indication clears when the load completes or aborts.

A load is started by any of these events:
- the primary reset;
- the secondary reset;
- the chip-reset control bit;
- a pulse marking a return from the D3hot power state to D0.

A new event in the middle of a load drops chip select and starts over from the beginning.

Top module: `cfg_preload_ctrl`

## Requirements
- R1: The serial clock period is DIV_NORM (34) system clocks when `fast_clk_sel` is 0, and DIV_FAST (68) when it is 1. Within each period the clock is high for exactly half the period.
- R2: Each load asserts `sr_sel` and first sends a 12-bit command, MSB first, on `sr_mosi`: `1`, `1`, `0`, then nine address zeros (12'hC00). `sr_mosi` changes only while `sr_clk` is low.
- R3: `sr_miso` is sampled on rising `sr_clk` edges, starting with the 14th edge; the 13th edge carries the dummy 0. Bytes are assembled MSB first. Each byte is written with a one-cycle `wr_en` pulse, with `wr_idx` counting 0 up to LOAD_BYTES-1 in order. `sr_sel` stays asserted for the whole transfer.
- R4: If the first two data bits are not 1 followed by 0, `sr_sel` drops and `cfg_retry` clears. No byte is written and `load_done` does not pulse.
- R5: With no EEPROM fitted (`sr_miso` constantly 1), the load aborts as in R4.
- R6: `cfg_retry` is 1 from any trigger until the load completes or aborts. `sr_sel` and `wr_en` are never active while `cfg_retry` is 0.
- R7: While `sec_rst_n` is 0 or `chip_rst_bit` is 1, `sr_sel` stays 0 and `cfg_retry` stays 1. A load begins only after both are released.
- R8: A `pm_d0_exit` pulse, or any other trigger, during a load drops `sr_sel` on the next clock edge. `sr_sel` then stays low for at least one serial clock period before a fresh load starts again from byte index 0.
- R9: After the last byte, `sr_sel` drops at the next falling serial clock. `load_done` pulses for exactly one cycle, in the same cycle that `cfg_retry` falls.
- R10: `prim_rst_n` low asynchronously forces `sr_sel`=0, `wr_en`=0, `load_done`=0 and `cfg_retry`=1. On release, a load starts by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| prim_rst_n | input | 1 | Primary reset, active low, asynchronous |
| sec_rst_n | input | 1 | Secondary reset, active low, synchronized inside |
| chip_rst_bit | input | 1 | Chip-reset control bit, active high, synchronized inside |
| pm_d0_exit | input | 1 | One-cycle pulse on a D3hot to D0 transition |
| fast_clk_sel | input | 1 | 1 selects the larger divider for a system clock above 33 MHz |
| sr_sel | output | 1 | EEPROM chip select |
| sr_clk | output | 1 | EEPROM serial clock |
| sr_mosi | output | 1 | Data toward the EEPROM |
| sr_miso | input | 1 | Data from the EEPROM, pulled high when absent |
| cfg_retry | output | 1 | Configuration accesses must be retried |
| wr_en | output | 1 | Byte write strobe toward the register file |
| wr_idx | output | ADDR_W | Byte index of the write |
| wr_data | output | 8 | Byte value of the write |
| load_done | output | 1 | One-cycle pulse when a load completes |

## Verification
The hardest case to reach from the ports is a trigger that lands in the middle of a transfer, after some bytes have already been written. The bench polls its own count of captured writes. After the third byte it fires a `pm_d0_exit` pulse and checks three things: chip select drops, the low gap before the next select is at least one serial period, and the writes start again from index 0. A second mid-load case asserts the primary reset away from any clock edge and checks the outputs immediately. The bench includes an EEPROM model that replays a computed image. By changing the image's first byte, the model drives every signature pattern: 10, 00, 01 and 11, where 11 also stands for an absent part.

// File: rtl/preload_pkg.sv
package preload_pkg;

   typedef enum logic [1:0] {
      PL_HOLD   = 2'd0,
      PL_GAP    = 2'd1,
      PL_ACTIVE = 2'd2,
      PL_IDLE   = 2'd3
   } pl_state_t;

   // start bit and sequential-read opcode, sent before the address
   localparam logic [2:0] START_OP = 3'b110;
   // first two data bits that permit loading
   localparam logic [1:0] SIG_OK   = 2'b10;
   // clock edges between the last address bit and the first data bit
   localparam int         DUMMY_EDGES = 1;

endpackage

// File: rtl/preload_trigger.sv
module preload_trigger #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_rst_n,
   input  logic chip_rst_bit,
   input  logic pm_d0_exit,
   output logic trig
);

   logic hold;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign hold = ~sec_rst_n | chip_rst_bit;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sec_q;
         logic [SYNC_STAGES-1:0] chip_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     sec_q[i]  <= 1'b0;
                     chip_q[i] <= 1'b1;
                  end else begin
                     sec_q[i]  <= sec_rst_n;
                     chip_q[i] <= chip_rst_bit;
                  end
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     sec_q[i]  <= 1'b0;
                     chip_q[i] <= 1'b1;
                  end else begin
                     sec_q[i]  <= sec_q[i-1];
                     chip_q[i] <= chip_q[i-1];
                  end
               end
            end
         end
         assign hold = ~sec_q[SYNC_STAGES-1] | chip_q[SYNC_STAGES-1];
      end
   endgenerate

   assign trig = hold | pm_d0_exit;

endmodule

// File: rtl/preload_sclk.sv
module preload_sclk #(
   parameter int DIV_NORM = 34,
   parameter int DIV_FAST = 68,
   parameter bit FAST_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fast,
   output logic sck,
   output logic rise_stb,
   output logic fall_stb
);

   localparam int CNT_W = $clog2(DIV_FAST + 1);

   logic [CNT_W-1:0] div;
   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] cnt;

   generate
      if (FAST_EN) begin : g_two_rates
         assign div = fast ? CNT_W'(DIV_FAST) : CNT_W'(DIV_NORM);
      end else begin : g_one_rate
         logic unused_fast;
         assign unused_fast = fast;
         assign div = CNT_W'(DIV_NORM);
      end
   endgenerate

   assign half     = div >> 1;
   assign rise_stb = en && (cnt == half - 1'b1);
   assign fall_stb = en && (cnt >= div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (fall_stb) begin
         cnt <= '0;
         sck <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (rise_stb) sck <= 1'b1;
      end
   end

endmodule

// File: rtl/preload_seq.sv
module preload_seq
   import preload_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int LOAD_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              miso,
   output pl_state_t         state,
   output logic              sel,
   output logic              mosi,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_idx,
   output logic [7:0]        wr_data,
   output logic              done
);

   localparam int CMD_LEN    = 3 + ADDR_W;
   localparam int DATA_START = CMD_LEN + DUMMY_EDGES;
   localparam int PH_W       = $clog2(DATA_START + 1);
   localparam logic [CMD_LEN-1:0] READ_CMD = {START_OP, {ADDR_W{1'b0}}};
   localparam logic [ADDR_W-1:0]  LAST_IDX = ADDR_W'(LOAD_BYTES - 1);

   logic [CMD_LEN-1:0] cmd_sr;
   logic [PH_W-1:0]    ph_cnt;
   logic [2:0]         bit_cnt;
   logic [6:0]         shreg;
   logic [ADDR_W-1:0]  byte_idx;
   logic               last_flag;
   logic               gap_seen;

   assign mosi = sel & cmd_sr[CMD_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PL_HOLD;
         sel       <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
         done      <= 1'b0;
         cmd_sr    <= '0;
         ph_cnt    <= '0;
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_idx  <= '0;
         last_flag <= 1'b0;
         gap_seen  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         done  <= 1'b0;
         if (trig) begin
            state <= PL_HOLD;
            sel   <= 1'b0;
         end else begin
            case (state)
               PL_HOLD: begin
                  state    <= PL_GAP;
                  gap_seen <= 1'b0;
               end
               PL_GAP: begin
                  if (fall_stb) begin
                     if (gap_seen) begin
                        state     <= PL_ACTIVE;
                        sel       <= 1'b1;
                        cmd_sr    <= READ_CMD;
                        ph_cnt    <= '0;
                        bit_cnt   <= '0;
                        byte_idx  <= '0;
                        last_flag <= 1'b0;
                     end else begin
                        gap_seen <= 1'b1;
                     end
                  end
               end
               PL_ACTIVE: begin
                  if (fall_stb) begin
                     cmd_sr <= {cmd_sr[CMD_LEN-2:0], 1'b0};
                     if (last_flag) begin
                        state <= PL_IDLE;
                        sel   <= 1'b0;
                        done  <= 1'b1;
                     end
                  end
                  if (rise_stb && !last_flag) begin
                     if (ph_cnt != PH_W'(DATA_START)) begin
                        ph_cnt <= ph_cnt + 1'b1;
                     end else begin
                        shreg   <= {shreg[5:0], miso};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_idx == '0 && bit_cnt == 3'd1 &&
                            {shreg[0], miso} != SIG_OK) begin
                           state <= PL_IDLE;
                           sel   <= 1'b0;
                        end
                        if (bit_cnt == 3'd7) begin
                           wr_en    <= 1'b1;
                           wr_idx   <= byte_idx;
                           wr_data  <= {shreg, miso};
                           byte_idx <= byte_idx + 1'b1;
                           if (byte_idx == LAST_IDX) last_flag <= 1'b1;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_preload_ctrl.sv
module cfg_preload_ctrl
   import preload_pkg::*;
#(
   parameter int DIV_NORM    = 34,
   parameter int DIV_FAST    = 68,
   parameter bit FAST_EN     = 1'b1,
   parameter int ADDR_W      = 9,
   parameter int LOAD_BYTES  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              prim_rst_n,
   input  logic              sec_rst_n,
   input  logic              chip_rst_bit,
   input  logic              pm_d0_exit,
   input  logic              fast_clk_sel,
   output logic              sr_sel,
   output logic              sr_clk,
   output logic              sr_mosi,
   input  logic              sr_miso,
   output logic              cfg_retry,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_idx,
   output logic [7:0]        wr_data,
   output logic              load_done
);

   if (DIV_NORM < 4 || (DIV_NORM % 2) != 0) begin : g_bad_norm
      $error("DIV_NORM must be even and at least 4");
   end
   if (DIV_FAST < DIV_NORM || (DIV_FAST % 2) != 0) begin : g_bad_fast
      $error("DIV_FAST must be even and not below DIV_NORM");
   end
   if (LOAD_BYTES < 1 || LOAD_BYTES > (1 << ADDR_W)) begin : g_bad_len
      $error("LOAD_BYTES must lie within the EEPROM address space");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   pl_state_t state;
   logic      trig_any;
   logic      sck;
   logic      rise_stb;
   logic      fall_stb;
   logic      div_en;

   assign div_en    = (state == PL_GAP) || (state == PL_ACTIVE);
   assign cfg_retry = (state != PL_IDLE);
   assign sr_clk    = sck & sr_sel;

   preload_trigger #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_trig (
      .clk          (clk),
      .rst_n        (prim_rst_n),
      .sec_rst_n    (sec_rst_n),
      .chip_rst_bit (chip_rst_bit),
      .pm_d0_exit   (pm_d0_exit),
      .trig         (trig_any)
   );

   preload_sclk #(
      .DIV_NORM (DIV_NORM),
      .DIV_FAST (DIV_FAST),
      .FAST_EN  (FAST_EN)
   ) u_sclk (
      .clk      (clk),
      .rst_n    (prim_rst_n),
      .en       (div_en),
      .fast     (fast_clk_sel),
      .sck      (sck),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   preload_seq #(
      .ADDR_W     (ADDR_W),
      .LOAD_BYTES (LOAD_BYTES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (prim_rst_n),
      .trig     (trig_any),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .miso     (sr_miso),
      .state    (state),
      .sel      (sr_sel),
      .mosi     (sr_mosi),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .done     (load_done)
   );

endmodule

// File: rtl/preload_chk.sv
module preload_chk #(
   parameter int ADDR_W   = 9,
   parameter int DIV_NORM = 34
) (
   input logic              clk,
   input logic              prim_rst_n,
   input logic              trig_any,
   input logic              sr_sel,
   input logic              cfg_retry,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx,
   input logic              load_done
);

   localparam int LOW_W = $clog2(DIV_NORM + 1) + 1;

   logic [LOW_W-1:0]  low_cnt;
   logic [ADDR_W-1:0] wcnt;
   logic              sel_q;

   always_ff @(posedge clk or negedge prim_rst_n) begin
      if (!prim_rst_n) begin
         low_cnt <= '0;
         wcnt    <= '0;
         sel_q   <= 1'b0;
      end else begin
         sel_q <= sr_sel;
         if (sr_sel) low_cnt <= '0;
         else if (low_cnt < LOW_W'(DIV_NORM)) low_cnt <= low_cnt + 1'b1;
         if (sr_sel && !sel_q) wcnt <= '0;
         else if (wr_en) wcnt <= wcnt + 1'b1;
      end
   end

   // R3: writes arrive with consecutive indices from 0 in each session
   a_r3_wr_order: assert property (@(posedge clk) disable iff (!prim_rst_n)
      wr_en |-> (wr_idx == wcnt));

   // R6: no write and no select once the retry indication is off
   a_r6_wr_in_load: assert property (@(posedge clk) disable iff (!prim_rst_n)
      wr_en |-> cfg_retry);
   a_r6_sel_needs_retry: assert property (@(posedge clk) disable iff (!prim_rst_n)
      !cfg_retry |-> !sr_sel);

   // R7: an active trigger keeps the EEPROM deselected and accesses retried
   a_r7_trig_holds: assert property (@(posedge clk) disable iff (!prim_rst_n)
      trig_any |=> (!sr_sel && cfg_retry));

   // R8: select rises only after a low gap of at least one serial period
   a_r8_sel_gap: assert property (@(posedge clk) disable iff (!prim_rst_n)
      (sr_sel && !sel_q) |-> (low_cnt >= LOW_W'(DIV_NORM)));

   // R9: done is a single pulse that coincides with retry release
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!prim_rst_n)
      load_done |=> !load_done);
   a_r9_done_retry: assert property (@(posedge clk) disable iff (!prim_rst_n)
      load_done |-> (!cfg_retry && !sr_sel && $past(cfg_retry)));

endmodule

bind cfg_preload_ctrl preload_chk #(
   .ADDR_W   (ADDR_W),
   .DIV_NORM (DIV_NORM)
) u_chk (
   .clk        (clk),
   .prim_rst_n (prim_rst_n),
   .trig_any   (trig_any),
   .sr_sel     (sr_sel),
   .cfg_retry  (cfg_retry),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .load_done  (load_done)
);

// File: tb/cfg_preload_ctrl_tb.sv
module cfg_preload_ctrl_tb;

   localparam int ADDR_W = 9;
   localparam int LB     = 8;
   localparam int DIVN   = 34;
   localparam int DIVF   = 68;

   // {first byte, fast_clk_sel, load expected}
   localparam logic [9:0] VEC [6] = '{
      {8'hA5, 2'b01}, {8'h80, 2'b11}, {8'h3F, 2'b00},
      {8'hC0, 2'b10}, {8'h40, 2'b00}, {8'hBE, 2'b11}
   };

   logic clk = 1'b0;
   logic prim_rst_n = 1'b0, sec_rst_n = 1'b0, chip_rst_bit = 1'b0;
   logic pm_d0_exit = 1'b0, fast_clk_sel = 1'b0, sr_miso = 1'b1;
   logic sr_sel, sr_clk, sr_mosi, cfg_retry, wr_en, load_done;
   logic [ADDR_W-1:0] wr_idx;
   logic [7:0] wr_data;

   always #5 clk = ~clk;

   cfg_preload_ctrl #(.DIV_NORM(DIVN), .DIV_FAST(DIVF), .ADDR_W(ADDR_W),
                      .LOAD_BYTES(LB)) u_dut (
      .clk(clk), .prim_rst_n(prim_rst_n), .sec_rst_n(sec_rst_n),
      .chip_rst_bit(chip_rst_bit), .pm_d0_exit(pm_d0_exit),
      .fast_clk_sel(fast_clk_sel), .sr_sel(sr_sel), .sr_clk(sr_clk),
      .sr_mosi(sr_mosi), .sr_miso(sr_miso), .cfg_retry(cfg_retry),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .load_done(load_done));

   int checks = 0, errors = 0, cyc = 0;
   bit fin = 0;
   bit no_rom = 0;
   logic [7:0] first_byte = 8'hA5;
   logic [7:0] cap [LB];
   int wr_cnt, done_cnt, done_bad, order_err, retry_bad, sel_rises;
   int rise_n, last_rise, meas_period, meas_high, low_run, last_low;
   logic [11:0] cmd_cap;
   bit prev_sel = 0, prev_sck = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] img(int k);
      if (k == 0) return first_byte;
      return 8'((k * 37 + int'(first_byte)) ^ 8'h5A);
   endfunction

   function automatic logic rom_bit(int e);
      logic [7:0] b;
      if (no_rom || e < 12) return 1'b1;
      if (e == 12) return 1'b0;
      b = img((e - 13) / 8);
      return b[7 - ((e - 13) % 8)];
   endfunction

   // EEPROM model and port monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (sr_sel && !prev_sel) begin
         rise_n = 0; sr_miso = 1'b1; last_low = low_run; sel_rises++;
      end
      if (!sr_sel) low_run++; else low_run = 0;
      if (sr_sel && sr_clk && !prev_sck) begin
         if (rise_n > 0) meas_period = cyc - last_rise;
         last_rise = cyc;
         if (rise_n < 12) cmd_cap = {cmd_cap[10:0], sr_mosi};
         rise_n++;
         sr_miso = rom_bit(rise_n);
      end
      if (sr_sel && !sr_clk && prev_sck) meas_high = cyc - last_rise;
      if (wr_en) begin
         if (int'(wr_idx) != wr_cnt) order_err++;
         if (int'(wr_idx) < LB) cap[wr_idx] = wr_data;
         wr_cnt++;
      end
      if (load_done) begin
         done_cnt++;
         if (cfg_retry || sr_sel) done_bad++;
      end
      if (!cfg_retry && sr_sel) retry_bad++;
      prev_sel = sr_sel;
      prev_sck = sr_clk & sr_sel;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      wr_cnt = 0; done_cnt = 0; done_bad = 0; order_err = 0;
      retry_bad = 0; sel_rises = 0; cmd_cap = '0;
      meas_period = 0; meas_high = 0;
      for (int i = 0; i < LB; i++) cap[i] = 8'h00;
   endtask

   task automatic pulse_chip();
      @(posedge clk); #1 chip_rst_bit = 1'b1; clear_mon();
      repeat (4) @(posedge clk);
      #1 chip_rst_bit = 1'b0;
   endtask

   task automatic wait_end(input string req);
      int n = 0;
      while (!cfg_retry && n < 40) begin @(negedge clk); #1; n++; end
      n = 0;
      while (cfg_retry && n < 30000) begin @(negedge clk); #1; n++; end
      chk(!cfg_retry, {req, " load end timeout"}, cfg_retry, 0);
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic check_good(input string tag, input int div);
      int bad = 0;
      for (int i = 0; i < LB; i++) if (cap[i] !== img(i)) bad++;
      chk(wr_cnt == LB, {tag, " R3 byte count"}, wr_cnt, LB);
      chk(order_err == 0, {tag, " R3 index order"}, order_err, 0);
      chk(bad == 0, {tag, " R3 byte values"}, bad, 0);
      chk(sel_rises == 1, {tag, " R3 single select session"}, sel_rises, 1);
      chk(cmd_cap == 12'hC00, {tag, " R2 read command"}, cmd_cap, 12'hC00);
      chk(meas_period == div, {tag, " R1 serial period"}, meas_period, div);
      chk(meas_high == div / 2, {tag, " R1 high time"}, meas_high, div / 2);
      chk(done_cnt == 1, {tag, " R9 done pulses"}, done_cnt, 1);
      chk(done_bad == 0, {tag, " R9 done with retry or select"}, done_bad, 0);
      chk(retry_bad == 0, {tag, " R6 select without retry"}, retry_bad, 0);
      chk(sr_sel == 1'b0, {tag, " R9 select released"}, sr_sel, 0);
   endtask

   initial begin
      clear_mon();
      low_run = 0; last_low = 0; rise_n = 0; last_rise = 0;
      // R10: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(cfg_retry == 1'b1, "R10 retry in reset", cfg_retry, 1);
      chk(sr_sel == 1'b0, "R10 select in reset", sr_sel, 0);
      chk(wr_en == 1'b0 && load_done == 1'b0, "R10 write/done in reset", wr_en, 0);

      // R7: secondary reset still held
      @(posedge clk); #1 prim_rst_n = 1'b1;
      repeat (300) @(negedge clk);
      #1;
      chk(sel_rises == 0 && cfg_retry, "R7 hold while sec reset low", sel_rises, 0);
      // R7: chip-reset bit still set
      @(posedge clk); #1 chip_rst_bit = 1'b1; sec_rst_n = 1'b1;
      repeat (300) @(negedge clk);
      #1;
      chk(sel_rises == 0 && cfg_retry, "R7 hold while chip bit set", sel_rises, 0);

      // R5: no EEPROM fitted
      no_rom = 1;
      @(posedge clk); #1 chip_rst_bit = 1'b0;
      wait_end("R5");
      chk(sel_rises == 1, "R5 session started", sel_rises, 1);
      chk(cmd_cap == 12'hC00, "R2 command before abort", cmd_cap, 12'hC00);
      chk(wr_cnt == 0, "R5 no writes", wr_cnt, 0);
      chk(done_cnt == 0, "R5 no done", done_cnt, 0);
      chk(sr_sel == 1'b0, "R5 select dropped", sr_sel, 0);
      no_rom = 0;

      // vector table: signature patterns and both clock rates
      for (int v = 0; v < 6; v++) begin
         first_byte   = VEC[v][9:2];
         fast_clk_sel = VEC[v][1];
         pulse_chip();
         wait_end("R4/R3");
         if (VEC[v][0]) begin
            check_good($sformatf("vec%0d", v), VEC[v][1] ? DIVF : DIVN);
         end else begin
            chk(wr_cnt == 0, $sformatf("vec%0d R4 no writes", v), wr_cnt, 0);
            chk(done_cnt == 0, $sformatf("vec%0d R4 no done", v), done_cnt, 0);
            chk(sel_rises == 1 && !sr_sel, $sformatf("vec%0d R4 select dropped", v), sr_sel, 0);
            chk(retry_bad == 0, $sformatf("vec%0d R6 select without retry", v), retry_bad, 0);
         end
      end

      // R8: power-state pulse in the middle of a load
      fast_clk_sel = 1'b0; first_byte = 8'hB3;
      pulse_chip();
      begin
         int n = 0;
         while (wr_cnt < 3 && n < 20000) begin @(negedge clk); #1; n++; end
      end
      chk(wr_cnt >= 3 && sr_sel, "R8 reached mid-load", wr_cnt, 3);
      @(posedge clk); #1 pm_d0_exit = 1'b1; clear_mon();
      @(posedge clk); #1 pm_d0_exit = 1'b0;
      @(negedge clk); #1;
      chk(sr_sel == 1'b0 && cfg_retry, "R8 select dropped on restart", sr_sel, 0);
      wait_end("R8");
      chk(last_low >= DIVN, "R8 low gap before reselect", last_low, DIVN);
      check_good("R8 restart", DIVN);

      // R10: primary reset mid-load, asserted away from a clock edge
      first_byte = 8'h9C;
      pulse_chip();
      begin
         int n = 0;
         while (wr_cnt < 2 && n < 20000) begin @(negedge clk); #1; n++; end
      end
      #2 prim_rst_n = 1'b0;
      #1;
      chk(sr_sel == 1'b0 && cfg_retry == 1'b1, "R10 async reset mid-load", sr_sel, 0);
      chk(wr_en == 1'b0 && load_done == 1'b0, "R10 outputs quiet in reset", wr_en, 0);
      repeat (3) @(posedge clk);
      #1 prim_rst_n = 1'b1; clear_mon();
      wait_end("R10");
      check_good("R10 reload", DIVN);

      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule